// File: doc/BRIEF.md
# Load Byte-Lane Format Decoder

This block turns the attributes of a load into the control word of a 64-bit load formatter, and applies that word to the raw doubleword. The inputs are the access size (byte, half, word or double), the byte order, the low three address bits and a signed flag. The formatter works in two steps. First it permutes the eight bytes of the doubleword into eight result lanes. Then it replaces each result lane above the loaded datum with zero or ones fill.

The mux behind the formatter is sparse. Result lanes 0 and 1 can draw from any of the eight source bytes. Lanes 2, 5 and 6 can draw only from source bytes 1, 2, 5 and 6. Lanes 3, 4 and 7 can draw only from source bytes 0, 3, 4 and 7. Every mux is an and-or structure with no priority, so the decoder must emit exactly one legal one-hot code per lane.

Each upper lane has two controls: a pass select and a ones-fill select. When both are low, the lane reads zero. A small datapath applies the controls and produces two results. The integer result carries the extension. The floating-point result receives the permuted bytes with no extension. The whole block is combinational.

Top module: `ldfmt_sel_decoder`

## Requirements
- R1: Source byte k is raw_data[8k+7:8k], and source byte 7 sits at the lowest address. With big_endian=1, acc_size S (0=byte, 1=half, 2=word, 3=double, N=2^S bytes) and an aligned offset A, result lane i < N carries source byte 7-A-(N-1)+i on both int_data and fp_data.
- R2: With big_endian=0 and an aligned offset, result lane i < N carries source byte 7-A-i on both int_data and fp_data.
- R3: sel_full0 and sel_full1 are the lane 0 and lane 1 selects. Bit k selects source byte k. For an aligned access, sel_full0 has exactly one bit set. sel_full1 has one bit set when N > 1 and is zero otherwise.
- R4: The select for lane i (2..7) is sel_narrow[4(i-2)+3 : 4(i-2)]. For lanes 2, 5 and 6, bits 0..3 pick source bytes 1, 2, 5 and 6. For lanes 3, 4 and 7, bits 0..3 pick source bytes 0, 3, 4 and 7. A lane at or above N has all select bits low.
- R5: For a signed load whose most significant datum byte has bit 7 set, every lane i >= N has ones_sel[i]=1 and pass_sel[i]=0, and reads 0xFF on int_data.
- R6: For an unsigned load, or a signed load with a clear sign bit, lanes i >= N have both selects low and read 0x00 on int_data.
- R7: pass_sel[i] is high exactly for the lanes 1 <= i < N of an aligned access.
- R8: fp_data carries the permuted bytes in lanes below N and zero in lanes at or above N. No ones fill ever appears on it.
- R9: An offset that is not a multiple of N raises err and drives every select low, so int_data and fp_data are both zero. An aligned access keeps err low.
- R10: pass_sel and ones_sel are never both high in the same lane, and no lane select ever has more than one bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| acc_size | input | 2 | Access size code: 0 byte, 1 half, 2 word, 3 double |
| addr_lo | input | 3 | Byte offset of the access within the doubleword |
| big_endian | input | 1 | 1 = big-endian access, 0 = little-endian |
| signed_ld | input | 1 | 1 = sign-extending load |
| raw_data | input | 64 | Doubleword read from the cache line |
| sel_full0 | output | 8 | One-hot source select for result lane 0 |
| sel_full1 | output | 8 | One-hot source select for result lane 1 |
| sel_narrow | output | 24 | Packed 4-bit one-hot selects for result lanes 2..7 |
| pass_sel | output | 7 | Per-lane pass-data select, lanes 1..7 |
| ones_sel | output | 7 | Per-lane ones-fill select, lanes 1..7 |
| err | output | 1 | Misaligned access flag |
| int_data | output | 64 | Formatted and extended integer result |
| fp_data | output | 64 | Permuted floating-point result, no extension |

## Verification
The block holds no state, so a wrong decode shows at the ports in the same cycle as the input that causes it. A wrong lane index shows up as a byte taken from the wrong source lane. A wrong sign-byte pick shows up as fill that disagrees with the datum's own top bit. A missed alignment case shows up as an err flag that is low while the data is non-zero. The sweep covers every combination of size, offset, byte order and signedness. It uses several data patterns, so that each source byte, and each sign bit, is seen both set and clear.

// File: rtl/ldfmt_pkg.sv
`timescale 1ns/1ps
package ldfmt_pkg;
    localparam int LANES        = 8;
    localparam int BYTE_W       = 8;
    localparam int DATA_W       = LANES * BYTE_W;
    localparam int IDX_W        = $clog2(LANES);
    localparam int GRP_W        = 4;
    localparam int NARROW_LANES = LANES - 2;
    localparam int NARROW_W     = NARROW_LANES * GRP_W;

    typedef enum logic [1:0] {
        ACC_BYTE = 2'd0,
        ACC_HALF = 2'd1,
        ACC_WORD = 2'd2,
        ACC_DBL  = 2'd3
    } acc_size_e;

    typedef struct packed {
        logic [LANES-1:0]    full0;
        logic [LANES-1:0]    full1;
        logic [NARROW_W-1:0] narrow;
        logic [LANES-1:1]    pass;
        logic [LANES-1:1]    ones;
        logic                err;
    } fmt_ctl_t;

    function automatic int acc_bytes(acc_size_e sz);
        return 1 << int'(sz);
    endfunction

    function automatic logic is_aligned(acc_size_e sz, logic [IDX_W-1:0] addr);
        return (int'(addr) % acc_bytes(sz)) == 0;
    endfunction

    // Byte index in the raw doubleword that feeds result lane `lane`.
    function automatic logic [IDX_W-1:0] src_index(int lane, acc_size_e sz,
                                                   logic [IDX_W-1:0] addr, logic be);
        int n;
        int v;
        n = acc_bytes(sz);
        if (be) v = (LANES - 1) - int'(addr) - (n - 1) + lane;
        else    v = (LANES - 1) - int'(addr) - lane;
        return IDX_W'(v);
    endfunction

    // Lanes 2, 5, 6 form group A; lanes 3, 4, 7 form group B.
    function automatic logic lane_in_grp_a(int lane);
        return (lane == 2) || (lane == 5) || (lane == 6);
    endfunction

    // Source byte reached by position p of a group mux.
    function automatic logic [IDX_W-1:0] grp_member(logic grp_a, logic [1:0] p);
        return grp_a ? {p[1], p[0], ~p[0]} : {p[1], p[0], p[0]};
    endfunction
endpackage

// File: rtl/ldfmt_lane_route.sv
`timescale 1ns/1ps
module ldfmt_lane_route
    import ldfmt_pkg::*;
#(
    parameter int LANE = 0
) (
    input  acc_size_e          size,
    input  logic [IDX_W-1:0]   addr,
    input  logic               big_endian,
    input  logic               valid,
    output logic [LANES-1:0]   onehot
);
    logic [IDX_W-1:0] idx;
    logic             in_datum;

    always_comb begin
        idx      = src_index(LANE, size, addr, big_endian);
        in_datum = valid && (LANE < acc_bytes(size));
        onehot   = '0;
        if (in_datum) onehot[idx] = 1'b1;
    end
endmodule

// File: rtl/ldfmt_ext_ctl.sv
`timescale 1ns/1ps
module ldfmt_ext_ctl
    import ldfmt_pkg::*;
(
    input  acc_size_e          size,
    input  logic [IDX_W-1:0]   addr,
    input  logic               big_endian,
    input  logic               signed_ld,
    input  logic [LANES-1:0]   src_msb,
    input  logic               valid,
    output logic [LANES-1:1]   pass,
    output logic [LANES-1:1]   ones
);
    logic [IDX_W-1:0] top_idx;
    logic             sign_fill;

    always_comb begin
        // Most significant datum byte lands in lane N-1.
        top_idx   = src_index(acc_bytes(size) - 1, size, addr, big_endian);
        sign_fill = signed_ld && src_msb[top_idx];
        for (int l = 1; l < LANES; l++) begin
            pass[l] = valid && (l <  acc_bytes(size));
            ones[l] = valid && (l >= acc_bytes(size)) && sign_fill;
        end
    end
endmodule

// File: rtl/ldfmt_apply.sv
`timescale 1ns/1ps
module ldfmt_apply
    import ldfmt_pkg::*;
(
    input  logic [DATA_W-1:0]   raw,
    input  logic [LANES-1:0]    full0,
    input  logic [LANES-1:0]    full1,
    input  logic [NARROW_W-1:0] narrow,
    input  logic [LANES-1:1]    pass,
    input  logic [LANES-1:1]    ones,
    output logic [DATA_W-1:0]   int_out,
    output logic [DATA_W-1:0]   fp_out
);
    logic [LANES-1:0][BYTE_W-1:0] src;
    logic [LANES-1:0][BYTE_W-1:0] perm;

    assign src = raw;

    generate
        for (genvar l = 0; l < LANES; l++) begin : g_lane
            if (l < 2) begin : g_full
                logic [LANES-1:0] sel;
                assign sel = (l == 0) ? full0 : full1;
                always_comb begin
                    perm[l] = '0;
                    for (int k = 0; k < LANES; k++)
                        perm[l] = perm[l] | ({BYTE_W{sel[k]}} & src[k]);
                end
            end else begin : g_narrow
                logic [GRP_W-1:0] sel;
                assign sel = narrow[(l-2)*GRP_W +: GRP_W];
                always_comb begin
                    perm[l] = '0;
                    for (int p = 0; p < GRP_W; p++)
                        perm[l] = perm[l] |
                            ({BYTE_W{sel[p]}} & src[grp_member(lane_in_grp_a(l), 2'(p))]);
                end
            end

            assign fp_out[l*BYTE_W +: BYTE_W] = perm[l];
            if (l == 0) begin : g_low
                assign int_out[BYTE_W-1:0] = perm[0];
            end else begin : g_ext
                assign int_out[l*BYTE_W +: BYTE_W] =
                    ({BYTE_W{pass[l]}} & perm[l]) | {BYTE_W{ones[l]}};
            end
        end
    endgenerate
endmodule

// File: rtl/ldfmt_sel_decoder.sv
`timescale 1ns/1ps
module ldfmt_sel_decoder
    import ldfmt_pkg::*;
(
    input  logic [1:0]          acc_size,
    input  logic [IDX_W-1:0]    addr_lo,
    input  logic                big_endian,
    input  logic                signed_ld,
    input  logic [DATA_W-1:0]   raw_data,
    output logic [LANES-1:0]    sel_full0,
    output logic [LANES-1:0]    sel_full1,
    output logic [NARROW_W-1:0] sel_narrow,
    output logic [LANES-1:1]    pass_sel,
    output logic [LANES-1:1]    ones_sel,
    output logic                err,
    output logic [DATA_W-1:0]   int_data,
    output logic [DATA_W-1:0]   fp_data
);
    acc_size_e        size;
    logic             valid;
    logic [LANES-1:0] src_msb;
    fmt_ctl_t         ctl;

    assign size  = acc_size_e'(acc_size);
    assign valid = is_aligned(size, addr_lo);

    generate
        for (genvar k = 0; k < LANES; k++) begin : g_msb
            assign src_msb[k] = raw_data[k*BYTE_W + BYTE_W - 1];
        end

        for (genvar l = 0; l < LANES; l++) begin : g_route
            logic [LANES-1:0] oh;
            ldfmt_lane_route #(.LANE(l)) u_route (
                .size       (size),
                .addr       (addr_lo),
                .big_endian (big_endian),
                .valid      (valid),
                .onehot     (oh)
            );
            if (l == 0) begin : g_l0
                assign ctl.full0 = oh;
            end else if (l == 1) begin : g_l1
                assign ctl.full1 = oh;
            end else if (lane_in_grp_a(l)) begin : g_ga
                assign ctl.narrow[(l-2)*GRP_W +: GRP_W] = {oh[6], oh[5], oh[2], oh[1]};
            end else begin : g_gb
                assign ctl.narrow[(l-2)*GRP_W +: GRP_W] = {oh[7], oh[4], oh[3], oh[0]};
            end
        end
    endgenerate

    ldfmt_ext_ctl u_ext (
        .size       (size),
        .addr       (addr_lo),
        .big_endian (big_endian),
        .signed_ld  (signed_ld),
        .src_msb    (src_msb),
        .valid      (valid),
        .pass       (ctl.pass),
        .ones       (ctl.ones)
    );

    assign ctl.err = !valid;

    ldfmt_apply u_apply (
        .raw     (raw_data),
        .full0   (ctl.full0),
        .full1   (ctl.full1),
        .narrow  (ctl.narrow),
        .pass    (ctl.pass),
        .ones    (ctl.ones),
        .int_out (int_data),
        .fp_out  (fp_data)
    );

    assign sel_full0  = ctl.full0;
    assign sel_full1  = ctl.full1;
    assign sel_narrow = ctl.narrow;
    assign pass_sel   = ctl.pass;
    assign ones_sel   = ctl.ones;
    assign err        = ctl.err;
endmodule

// File: rtl/ldfmt_sel_checker.sv
`timescale 1ns/1ps
module ldfmt_sel_checker
    import ldfmt_pkg::*;
(
    input logic [1:0]          acc_size,
    input logic [IDX_W-1:0]    addr_lo,
    input logic                big_endian,
    input logic                signed_ld,
    input logic [DATA_W-1:0]   raw_data,
    input logic [LANES-1:0]    sel_full0,
    input logic [LANES-1:0]    sel_full1,
    input logic [NARROW_W-1:0] sel_narrow,
    input logic [LANES-1:1]    pass_sel,
    input logic [LANES-1:1]    ones_sel,
    input logic                err,
    input logic [DATA_W-1:0]   int_data,
    input logic [DATA_W-1:0]   fp_data
);
    always_comb begin
        if (!$isunknown({acc_size, addr_lo, big_endian, signed_ld, raw_data})) begin
            a_r10_full0_onehot: assert ($onehot0(sel_full0))
                else $error("R10 lane 0 select not one-hot");
            a_r10_full1_onehot: assert ($onehot0(sel_full1))
                else $error("R10 lane 1 select not one-hot");
            a_r3_lane0_present: assert (err || $onehot(sel_full0))
                else $error("R3 aligned access without lane 0 source");
            a_r9_err_quiet: assert (!err || (sel_full0 == '0 && sel_full1 == '0 &&
                                    sel_narrow == '0 && pass_sel == '0 &&
                                    ones_sel == '0 && int_data == '0 && fp_data == '0))
                else $error("R9 misaligned access left selects or data active");
            for (int k = 0; k < NARROW_LANES; k++) begin
                a_r10_narrow_onehot: assert ($onehot0(sel_narrow[k*GRP_W +: GRP_W]))
                    else $error("R10 narrow lane select not one-hot");
            end
            for (int l = 1; l < LANES; l++) begin
                a_r10_excl: assert (!(pass_sel[l] && ones_sel[l]))
                    else $error("R10 pass and fill both high");
                a_r5_fill_ff: assert (!ones_sel[l] || int_data[l*BYTE_W +: BYTE_W] == 8'hFF)
                    else $error("R5 ones fill not 0xFF");
                a_r6_zero_fill: assert (pass_sel[l] || ones_sel[l] ||
                                        int_data[l*BYTE_W +: BYTE_W] == 8'h00)
                    else $error("R6 idle lane not zero");
                a_r8_fp_match: assert (!pass_sel[l] ||
                        int_data[l*BYTE_W +: BYTE_W] == fp_data[l*BYTE_W +: BYTE_W])
                    else $error("R8 passed lane differs between outputs");
                a_r7_pass_sourced: assert (!pass_sel[l] ||
                        ((l == 1) ? (sel_full1 != '0)
                                  : (sel_narrow[(l-2)*GRP_W +: GRP_W] != '0)))
                    else $error("R7 passed lane without a source");
            end
        end
    end
endmodule

bind ldfmt_sel_decoder ldfmt_sel_checker u_chk (.*);

// File: tb/ldfmt_sel_decoder_bench.sv
`timescale 1ns/1ps
module ldfmt_sel_decoder_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  acc_size = '0;
    logic [2:0]  addr_lo = '0;
    logic        big_endian = 1'b0;
    logic        signed_ld = 1'b0;
    logic [63:0] raw_data = '0;
    logic [7:0]  sel_full0, sel_full1;
    logic [23:0] sel_narrow;
    logic [7:1]  pass_sel, ones_sel;
    logic        err;
    logic [63:0] int_data, fp_data;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    ldfmt_sel_decoder u_ldfmt_sel_decoder (
        .acc_size   (acc_size),
        .addr_lo    (addr_lo),
        .big_endian (big_endian),
        .signed_ld  (signed_ld),
        .raw_data   (raw_data),
        .sel_full0  (sel_full0),
        .sel_full1  (sel_full1),
        .sel_narrow (sel_narrow),
        .pass_sel   (pass_sel),
        .ones_sel   (ones_sel),
        .err        (err),
        .int_data   (int_data),
        .fp_data    (fp_data)
    );

    task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h (size=%0d addr=%0d be=%0d sg=%0d data=%h)",
                     req, what, act, exp, acc_size, addr_lo, big_endian, signed_ld, raw_data);
        end
    endtask

    function automatic logic [63:0] pattern(int p);
        case (p)
            0: return 64'h0123_4567_89AB_CDEF;
            1: return 64'hF0E1_D2C3_B4A5_9687;
            2: return 64'h807F_8000_7F80_FF01;
            3: return 64'h11A2_33C4_55E6_7788;
            default: return 64'h7E81_02FD_9C63_4AB5;
        endcase
    endfunction

    task automatic run_case(int sz, int a, int be, int sg, logic [63:0] d);
        int n, msb_idx, idx;
        bit sign;
        logic [63:0] e_int, e_fp;
        logic [7:0]  e_f0, e_f1;
        logic [23:0] e_nar;
        logic [7:1]  e_pass, e_ones;
        string map_req;
        @(posedge clk);
        acc_size   = 2'(sz);
        addr_lo    = 3'(a);
        big_endian = be[0];
        signed_ld  = sg[0];
        raw_data   = d;
        @(negedge clk);
        n = 1 << sz;
        if ((a % n) != 0) begin
            chk("R9", "err", {63'd0, err}, 64'd1);
            chk("R9", "int_data", int_data, 64'd0);
            chk("R9", "fp_data", fp_data, 64'd0);
            chk("R9", "selects", {sel_full0, sel_full1, sel_narrow, pass_sel, ones_sel}, 64'd0);
            return;
        end
        map_req = be ? "R1" : "R2";
        msb_idx = be ? (7 - a) : (7 - a - (n - 1));
        sign    = (sg != 0) && d[8*msb_idx + 7];
        e_int = '0; e_fp = '0; e_f0 = '0; e_f1 = '0; e_nar = '0; e_pass = '0; e_ones = '0;
        for (int l = 0; l < 8; l++) begin
            if (l < n) begin
                idx = be ? (7 - a - (n - 1) + l) : (7 - a - l);
                e_int[8*l +: 8] = d[8*idx +: 8];
                e_fp[8*l +: 8]  = d[8*idx +: 8];
                if (l == 0)      e_f0[idx] = 1'b1;
                else if (l == 1) e_f1[idx] = 1'b1;
                else             e_nar[4*(l-2) + (idx >> 1)] = 1'b1;
                if (l >= 1) e_pass[l] = 1'b1;
            end else begin
                e_int[8*l +: 8] = sign ? 8'hFF : 8'h00;
                e_ones[l] = sign;
            end
        end
        chk("R9", "err", {63'd0, err}, 64'd0);
        chk(map_req, "int_data low lanes", int_data & ~({64{1'b1}} << (8*n)) , e_int & ~({64{1'b1}} << (8*n)));
        chk(sign ? "R5" : "R6", "int_data", int_data, e_int);
        chk("R8", "fp_data", fp_data, e_fp);
        chk("R3", "sel_full0", {56'd0, sel_full0}, {56'd0, e_f0});
        chk("R3", "sel_full1", {56'd0, sel_full1}, {56'd0, e_f1});
        chk("R4", "sel_narrow", {40'd0, sel_narrow}, {40'd0, e_nar});
        chk("R7", "pass_sel", {57'd0, pass_sel}, {57'd0, e_pass});
        chk(sign ? "R5" : "R6", "ones_sel", {57'd0, ones_sel}, {57'd0, e_ones});
        chk("R10", "pass/fill overlap", {57'd0, pass_sel & ones_sel}, 64'd0);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=complete");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // Reset-time inputs: unsigned little-endian byte at offset 0 of zero data.
        chk("R9", "reset err", {63'd0, err}, 64'd0);
        chk("R6", "reset int_data", int_data, 64'd0);
        rst = 1'b0;
        for (int sz = 0; sz < 4; sz++)
            for (int a = 0; a < 8; a++)
                for (int be = 0; be < 2; be++)
                    for (int sg = 0; sg < 2; sg++)
                        for (int p = 0; p < 5; p++)
                            run_case(sz, a, be, sg, pattern(p));
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule